// File: doc/BRIEF.md
# NAND Sector Hamming Check and Repair

This block judges one 512-byte NAND sector that is guarded by a 24-bit single-error-correcting parity code. It takes the raw parity word produced by the data-path parity engine, packs and inverts it into the 24-bit stored form, and compares that against the 24-bit code read back from the spare area. Because the stored form is the complement of the packed parity, an erased sector (all-ones data and all-ones spare) compares clean.

The XOR of the two codes is the error pattern. Its halves are 12 bits each. When the high half is the exact complement of the low half, one data bit flipped and the high half names it: the top nine bits give the byte and the next three give the bit. A pattern with a single set bit means the spare-area code itself was hit. Anything else cannot be repaired. With repair enabled, a data error is fixed in place by a single read-modify-write on a byte-wide buffer port.

The packed code output also serves the write path: it is the value to store in the spare area for the sector whose parity is on the raw input.

Top module: `nand_secc_check`

## Requirements
- R1: `code_o` equals the bitwise inverse of {`calc_raw_i[27:16]`, `calc_raw_i[11:0]`}; raw bits 31:28 and 15:12 have no effect on it.
- R2: The error pattern is `code_o` XOR `stored_code_i`, taken when a start is accepted; an all-zero pattern gives status 2'b00 (clean).
- R3: If pattern bits 23:12 XOR bits 11:0 equal 12'hFFF, status is 2'b01 (data error), `byte_idx_o` = pattern bits 23:15 and `bit_idx_o` = pattern bits 14:12.
- R4: A pattern meeting the R3 test whose byte index is not below SECTOR_BYTES gives status 2'b11.
- R5: A pattern with exactly one set bit gives status 2'b10 (error in stored code) and causes no buffer access.
- R6: Every other non-zero pattern gives status 2'b11; for every status other than 2'b01 the byte and bit indexes read zero.
- R7: `done_o` is high for exactly one cycle: the second cycle after the clock edge that samples `start_i` when no repair is made, the fourth when a repair is made.
- R8: When `fix_en_i` is high at start and status is 2'b01, the block pulses `buf_rd_o` for one cycle at the byte index, then in the next cycle pulses `buf_wr_o` at the same address with the read byte (returned on `buf_rdata_i` one cycle after the read strobe) XOR a mask holding a single 1 at the bit index; no buffer strobe occurs otherwise.
- R9: `start_i` is ignored while a check is in progress.
- R10: After reset status, indexes, `done_o` and both strobes are zero; status and indexes keep their value after done until the next check updates them, regardless of input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to check a sector |
| fix_en_i | input | 1 | Apply a data repair through the buffer port |
| calc_raw_i | input | 32 | Raw parity word computed over the received sector |
| stored_code_i | input | 24 | Code read back from the spare area |
| code_o | output | 24 | Packed, inverted form of `calc_raw_i` |
| status_o | output | 2 | 00 clean, 01 data error, 10 code error, 11 uncorrectable |
| byte_idx_o | output | 9 | Byte offset of a data error |
| bit_idx_o | output | 3 | Bit position of a data error within its byte |
| done_o | output | 1 | One-cycle completion pulse |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | 9 | Buffer byte address |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data, valid one cycle after `buf_rd_o` |

## Verification
The assertions assume `start_i` is a pulse and that the buffer answers a read strobe with data in the following cycle; no check covers a buffer that stalls. The bench drives `start_i` for one cycle on the falling edge, holds the codes stable until `done_o`, and models the buffer as a registered byte array with exactly that one-cycle read latency. The single deliberate break of the pulse rule is a start raised mid-repair, used to show it is dropped.

// File: rtl/nand_secc_pkg.sv
package nand_secc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_DATA  = 2'b01,
    ST_CODE  = 2'b10,
    ST_FAIL  = 2'b11
  } ecc_stat_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_RD,
    S_WR,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/nsc_code_pack.sv
module nsc_code_pack #(
  parameter int unsigned RAW_W      = 32,
  parameter int unsigned CODE_HALF  = 12,
  parameter int unsigned RAW_HI_LSB = 16,
  localparam int unsigned CODE_W    = 2 * CODE_HALF
) (
  input  logic [RAW_W-1:0]  raw_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] packed_w;

  // low half and high half lifted from separated raw fields
  for (genvar g = 0; g < CODE_HALF; g++) begin : g_pack
    assign packed_w[g]             = raw_i[g];
    assign packed_w[CODE_HALF + g] = raw_i[RAW_HI_LSB + g];
  end

  // stored inverted so an erased sector checks clean
  assign code_o = ~packed_w;
endmodule

// File: rtl/nsc_classify.sv
module nsc_classify
  import nand_secc_pkg::*;
#(
  parameter int unsigned CODE_HALF    = 12,
  parameter int unsigned BIT_W        = 3,
  parameter int unsigned SECTOR_BYTES = 512,
  localparam int unsigned CODE_W      = 2 * CODE_HALF,
  localparam int unsigned BYTE_W      = CODE_HALF - BIT_W
) (
  input  logic [CODE_W-1:0] pat_i,
  output ecc_stat_e         stat_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [BIT_W-1:0]  bit_o
);
  localparam logic [BYTE_W:0] LIMIT = (BYTE_W + 1)'(SECTOR_BYTES);

  logic [CODE_HALF-1:0] syn;
  logic [BYTE_W-1:0]    byte_f;
  logic [BIT_W-1:0]     bit_f;

  assign syn    = pat_i[CODE_W-1:CODE_HALF] ^ pat_i[CODE_HALF-1:0];
  assign byte_f = pat_i[CODE_W-1 -: BYTE_W];
  assign bit_f  = pat_i[CODE_HALF +: BIT_W];

  always_comb begin
    stat_o = ST_FAIL;
    byte_o = '0;
    bit_o  = '0;
    if (pat_i == '0) begin
      stat_o = ST_CLEAN;
    end else if (&syn) begin
      if ({1'b0, byte_f} < LIMIT) begin
        stat_o = ST_DATA;
        byte_o = byte_f;
        bit_o  = bit_f;
      end
    end else if ($onehot(pat_i)) begin
      stat_o = ST_CODE;
    end
  end
endmodule

// File: rtl/nsc_seq.sv
module nsc_seq
  import nand_secc_pkg::*;
#(
  parameter int unsigned CODE_W = 24,
  parameter int unsigned BYTE_W = 9,
  parameter int unsigned BIT_W  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fix_en_i,
  input  logic [CODE_W-1:0] stored_i,
  input  logic [CODE_W-1:0] calc_i,
  output logic [CODE_W-1:0] pat_o,
  input  ecc_stat_e         cls_stat_i,
  input  logic [BYTE_W-1:0] cls_byte_i,
  input  logic [BIT_W-1:0]  cls_bit_i,
  output ecc_stat_e         stat_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              done_o,
  output logic              buf_rd_o,
  output logic              buf_wr_o,
  output logic [BYTE_W-1:0] buf_addr_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  input  logic [DATA_W-1:0] buf_rdata_i
);
  seq_state_e        state_q;
  logic [CODE_W-1:0] pat_q;
  logic              fix_q;
  ecc_stat_e         stat_q;
  logic [BYTE_W-1:0] byte_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] flip_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pat_q   <= '0;
      fix_q   <= 1'b0;
      stat_q  <= ST_CLEAN;
      byte_q  <= '0;
      bit_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          pat_q   <= stored_i ^ calc_i;
          fix_q   <= fix_en_i;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          stat_q  <= cls_stat_i;
          byte_q  <= cls_byte_i;
          bit_q   <= cls_bit_i;
          state_q <= (fix_q && cls_stat_i == ST_DATA) ? S_RD : S_DONE;
        end
        S_RD:    state_q <= S_WR;
        S_WR:    state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign flip_mask[g] = (bit_q == BIT_W'(g));
  end

  assign pat_o       = pat_q;
  assign stat_o      = stat_q;
  assign byte_o      = byte_q;
  assign bit_o       = bit_q;
  assign done_o      = (state_q == S_DONE);
  assign buf_rd_o    = (state_q == S_RD);
  assign buf_wr_o    = (state_q == S_WR);
  assign buf_addr_o  = byte_q;
  assign buf_wdata_o = buf_rdata_i ^ flip_mask;

  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_rd_o && buf_wr_o));
  assert_wr_after_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> $past(buf_rd_o));
  assert_mask_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> $countones(buf_wdata_o ^ buf_rdata_i) == 1);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && start_i) |=> state_q != S_EVAL);
  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_EVAL) |=> ($stable(stat_q) && $stable(byte_q) && $stable(bit_q)));
endmodule

// File: rtl/nand_secc_check.sv
module nand_secc_check
  import nand_secc_pkg::*;
#(
  parameter int unsigned RAW_W        = 32,
  parameter int unsigned RAW_HI_LSB   = 16,
  parameter int unsigned CODE_HALF    = 12,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SECTOR_BYTES = 512,
  localparam int unsigned CODE_W      = 2 * CODE_HALF,
  localparam int unsigned BIT_W       = $clog2(DATA_W),
  localparam int unsigned BYTE_W      = CODE_HALF - BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fix_en_i,
  input  logic [RAW_W-1:0]  calc_raw_i,
  input  logic [CODE_W-1:0] stored_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        status_o,
  output logic [BYTE_W-1:0] byte_idx_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic              done_o,
  output logic              buf_rd_o,
  output logic              buf_wr_o,
  output logic [BYTE_W-1:0] buf_addr_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  input  logic [DATA_W-1:0] buf_rdata_i
);
  localparam logic [BYTE_W:0] LIMIT = (BYTE_W + 1)'(SECTOR_BYTES);

  logic [CODE_W-1:0] pat;
  ecc_stat_e         cls_stat;
  logic [BYTE_W-1:0] cls_byte;
  logic [BIT_W-1:0]  cls_bit;
  ecc_stat_e         stat;

  nsc_code_pack #(
    .RAW_W(RAW_W), .CODE_HALF(CODE_HALF), .RAW_HI_LSB(RAW_HI_LSB)
  ) u_pack (
    .raw_i(calc_raw_i), .code_o(code_o)
  );

  nsc_classify #(
    .CODE_HALF(CODE_HALF), .BIT_W(BIT_W), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_cls (
    .pat_i(pat), .stat_o(cls_stat), .byte_o(cls_byte), .bit_o(cls_bit)
  );

  nsc_seq #(
    .CODE_W(CODE_W), .BYTE_W(BYTE_W), .BIT_W(BIT_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .fix_en_i(fix_en_i),
    .stored_i(stored_code_i), .calc_i(code_o), .pat_o(pat),
    .cls_stat_i(cls_stat), .cls_byte_i(cls_byte), .cls_bit_i(cls_bit),
    .stat_o(stat), .byte_o(byte_idx_o), .bit_o(bit_idx_o), .done_o(done_o),
    .buf_rd_o(buf_rd_o), .buf_wr_o(buf_wr_o), .buf_addr_o(buf_addr_o),
    .buf_wdata_o(buf_wdata_o), .buf_rdata_i(buf_rdata_i)
  );

  assign status_o = stat;

  assert_data_in_sector_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_DATA) |-> ({1'b0, byte_idx_o} < LIMIT));
  assert_idx_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != ST_DATA) |-> (byte_idx_o == '0 && bit_idx_o == '0));
  assert_rd_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_o |-> (status_o == ST_DATA && buf_addr_o == byte_idx_o));
endmodule

// File: tb/tb_nand_secc_check.sv
module tb_nand_secc_check;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic [31:0] raw;
    logic [23:0] stored;
    logic        fix;
    logic [1:0]  st;
    logic [8:0]  byt;
    logic [2:0]  bt;
    logic [1:0]  st_lim;
  } vec_t;

  // status codes and field positions per R2..R6; lim instance has SECTOR_BYTES=300
  localparam vec_t VECS [NV] = '{
    '{32'hF123F456, 24'hEDCBA9, 1'b0, 2'b00, 9'd0,   3'd0, 2'b00},
    '{32'hF000F000, 24'hFFFFFF, 1'b0, 2'b00, 9'd0,   3'd0, 2'b00},
    '{32'h00000000, 24'hFD402B, 1'b1, 2'b01, 9'd5,   3'd3, 2'b01},
    '{32'h00000000, 24'h000FFF, 1'b1, 2'b01, 9'd511, 3'd7, 2'b11},
    '{32'h00000000, 24'hFFF000, 1'b1, 2'b01, 9'd0,   3'd0, 2'b01},
    '{32'h00000000, 24'hFFFFFE, 1'b1, 2'b10, 9'd0,   3'd0, 2'b10},
    '{32'h00000000, 24'h7FFFFF, 1'b1, 2'b10, 9'd0,   3'd0, 2'b10},
    '{32'h00000000, 24'hFFFFFC, 1'b1, 2'b11, 9'd0,   3'd0, 2'b11},
    '{32'h00000000, 24'hEDCBA9, 1'b1, 2'b11, 9'd0,   3'd0, 2'b11},
    '{32'hF123F456, 24'h7BED34, 1'b1, 2'b01, 9'd300, 3'd2, 2'b11},
    '{32'h00000000, 24'hFD402B, 1'b0, 2'b01, 9'd5,   3'd3, 2'b01}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fix_en = 1'b0;
  logic [31:0] raw = '0;
  logic [23:0] stored = '0;
  logic [23:0] code;
  logic [1:0]  status;
  logic [8:0]  byte_idx;
  logic [2:0]  bit_idx;
  logic        done, buf_rd, buf_wr;
  logic [8:0]  buf_addr;
  logic [7:0]  buf_wdata, buf_rdata;

  logic [23:0] l_code;
  logic [1:0]  l_status;
  logic [8:0]  l_byte, l_addr;
  logic [2:0]  l_bit;
  logic        l_done, l_rd, l_wr;
  logic [7:0]  l_wdata;

  logic [7:0]  mem [512];
  logic [7:0]  exp_mem [512];
  int          wr_cnt = 0;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_secc_check dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fix_en_i(fix_en),
    .calc_raw_i(raw), .stored_code_i(stored), .code_o(code),
    .status_o(status), .byte_idx_o(byte_idx), .bit_idx_o(bit_idx),
    .done_o(done), .buf_rd_o(buf_rd), .buf_wr_o(buf_wr),
    .buf_addr_o(buf_addr), .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata)
  );

  nand_secc_check #(.SECTOR_BYTES(300)) dut_lim (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fix_en_i(1'b0),
    .calc_raw_i(raw), .stored_code_i(stored), .code_o(l_code),
    .status_o(l_status), .byte_idx_o(l_byte), .bit_idx_o(l_bit),
    .done_o(l_done), .buf_rd_o(l_rd), .buf_wr_o(l_wr),
    .buf_addr_o(l_addr), .buf_wdata_o(l_wdata), .buf_rdata_i(8'h00)
  );

  // buffer model: read data one cycle after strobe
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'(i) ^ 8'hA5;
      buf_rdata <= '0;
    end else begin
      if (buf_rd) buf_rdata <= mem[buf_addr];
      if (buf_wr) begin
        mem[buf_addr] <= buf_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != exp_mem[i]) bad++;
    check(req, "buffer mismatching bytes", bad, 0);
  endtask

  // pulse start, return cycles until done seen (first counted edge samples start)
  task automatic run(input logic [31:0] r, input logic [23:0] s, input logic f, output int lat);
    raw = r; stored = s; fix_en = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, w0;
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reset status", status, 0);
    check("R10", "reset byte", byte_idx, 0);
    check("R10", "reset bit", bit_idx, 0);
    check("R10", "reset done", done, 0);
    check("R10", "reset strobes", {buf_rd, buf_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 packing and inversion, ignored raw bits
    raw = 32'hF123F456; #1;
    check("R1", "code_o packed", code, 24'hEDCBA9);
    raw = 32'h0123_0456; #1;
    check("R1", "code_o ignores bits 31:28/15:12", code, 24'hEDCBA9);
    raw = 32'hF000F000; #1;
    check("R1", "code_o erased", code, 24'hFFFFFF);

    // table walk: R2..R8
    for (int v = 0; v < NV; v++) begin
      int exp_lat;
      bit repair;
      repair  = VECS[v].fix && VECS[v].st == 2'b01;
      exp_lat = repair ? 4 : 2;
      w0 = wr_cnt;
      run(VECS[v].raw, VECS[v].stored, VECS[v].fix, lat);
      if (repair) exp_mem[VECS[v].byt] = exp_mem[VECS[v].byt] ^ (8'h01 << VECS[v].bt);
      check("R7", $sformatf("v%0d done latency", v), lat, exp_lat);
      check("R2 R3 R5 R6", $sformatf("v%0d status", v), status, VECS[v].st);
      check("R3 R6", $sformatf("v%0d byte index", v), byte_idx, VECS[v].byt);
      check("R3 R6", $sformatf("v%0d bit index", v), bit_idx, VECS[v].bt);
      check("R4", $sformatf("v%0d limited sector status", v), l_status, VECS[v].st_lim);
      @(negedge clk);
      check("R7", $sformatf("v%0d done one cycle", v), done, 0);
      check("R5 R8", $sformatf("v%0d buffer writes", v), wr_cnt - w0, repair ? 1 : 0);
      check_mem("R8");
      // R10 results held without start
      stored = ~stored; raw = ~raw;
      repeat (2) @(negedge clk);
      check("R10", $sformatf("v%0d status held", v), status, VECS[v].st);
      check("R10", $sformatf("v%0d byte held", v), byte_idx, VECS[v].byt);
    end

    // R9 start during repair is dropped
    w0 = wr_cnt;
    raw = '0; stored = 24'hFFF000; fix_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R8", "read strobe in repair", buf_rd, 1);
    check("R8", "read address", buf_addr, 0);
    stored = 24'hFFFFFE; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8", "write strobe after read", buf_wr, 1);
    check("R8", "write data", buf_wdata, exp_mem[0] ^ 8'h01);
    @(negedge clk);
    exp_mem[0] = exp_mem[0] ^ 8'h01;
    check("R9", "done after busy start", done, 1);
    lat = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) lat++;
    end
    check("R9", "no extra done", lat, 0);
    check("R9", "status kept", status, 2'b01);
    check("R9", "single write", wr_cnt - w0, 1);
    check_mem("R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule